// File: doc/BRIEF.md
# CSR Access Legality Checker

This block sits between the instruction decoder and the control and status register file of a machine-mode-only RISC-V core. For every Zicsr instruction (the register forms CSRRW, CSRRS, CSRRC and the immediate forms CSRRWI, CSRRSI, CSRRCI) it works out what the instruction will actually do to the addressed register. The result is a plain read, a full write, a bit set or a bit clear. It also raises the write enable that the register file uses.

A set or clear whose source is zero changes no bit, so the block turns it into a pure read. That read is then legal even on a read-only register. An access to a register the file reports as not implemented raises an illegal-instruction exception. So does any real write to a read-only register. The exception carries the machine cause code for an illegal instruction, and its trap value is the offending instruction word. The write enable fires only for an instruction that is valid and not stalled. A stalled instruction therefore can never write the same register on several cycles.

All outputs are registered. They show the verdict for the instruction presented at the previous rising clock edge.

Top module: `csrchk_top`

## Requirements
- R1: While reset is high, and in the cycle after it, `csr_we_o` and `illegal_o` are 0, `eff_op_o` is 2'b00 (read), and `cause_o` and `tval_o` are 0.
- R2: `funct3_i` 3'b001 (register write) and 3'b101 (immediate write), on a legal access, give `eff_op_o` = 2'b01 and `csr_we_o` = 1 whatever the source value.
- R3: `funct3_i` 3'b010 (register set) or 3'b011 (register clear) with `src_i` = 0 gives `eff_op_o` = 2'b00 and `csr_we_o` = 0.
- R4: `funct3_i` 3'b110 (immediate set) or 3'b111 (immediate clear) with a zero immediate in `src_i` gives `eff_op_o` = 2'b00 and `csr_we_o` = 0.
- R5: A set with a nonzero source gives `eff_op_o` = 2'b10, and a clear gives 2'b11. On a legal access, `csr_we_o` = 1 in both cases.
- R6: Any CSR instruction with `csr_impl_i` = 0 raises `illegal_o`, even when its effect is a read.
- R7: A register is read-only when `csr_addr_i[11:10]` = 2'b11. A write, set or clear that would change it raises `illegal_o`. A suppressed set or clear (R3, R4) on such a register is legal.
- R8: When `illegal_o` is 1, `csr_we_o` is 0 and `eff_op_o` is 2'b00.
- R9: When `illegal_o` is 1, `cause_o` = 2 and `tval_o` is the instruction word of that instruction. Otherwise both are 0.
- R10: If `instr_valid_i` is 0 or `stall_i` is 1 at an edge, the following cycle has `csr_we_o` = 0, `illegal_o` = 0 and `eff_op_o` = 2'b00.
- R11: `funct3_i` 3'b000 or 3'b100 is no CSR access. It gives no write, no exception and `eff_op_o` = 2'b00.
- R12: The outputs reflect the inputs sampled at the previous rising edge, one verdict per accepted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| instr_valid_i | input | 1 | A CSR instruction is presented |
| stall_i | input | 1 | Pipeline stall; the instruction is not accepted this cycle |
| funct3_i | input | 3 | Operation field of the instruction |
| src_i | input | 5 | rs1 index or 5-bit immediate |
| csr_addr_i | input | 12 | Target CSR address |
| csr_impl_i | input | 1 | CSR file reports the address as implemented |
| instr_i | input | 32 | Full instruction word |
| eff_op_o | output | 2 | Effective operation: 00 read, 01 write, 10 set, 11 clear |
| csr_we_o | output | 1 | Write enable to the CSR file |
| illegal_o | output | 1 | Illegal-instruction exception |
| cause_o | output | 32 | Exception cause code |
| tval_o | output | 32 | Exception trap value |

## Verification
A wrong decision would appear one cycle after the instruction is accepted. If the zero-source suppression is missing, a spurious `csr_we_o` shows up, and it also shows up as a false exception on read-only registers. If the legality state is stale or wrong, `illegal_o` is missing or spurious, or `tval_o` differs from the instruction word just presented. A write enable that leaks through a stall is caught in the very next cycle. Every verdict is fully visible after one edge, so no error stays hidden beyond that cycle.

// File: rtl/csrchk_pkg.sv
package csrchk_pkg;

    typedef enum logic [1:0] {
        CSR_RD  = 2'b00,
        CSR_WR  = 2'b01,
        CSR_SET = 2'b10,
        CSR_CLR = 2'b11
    } csr_eff_e;

    localparam logic [2:0] F3_RW  = 3'b001;
    localparam logic [2:0] F3_RS  = 3'b010;
    localparam logic [2:0] F3_RC  = 3'b011;
    localparam logic [2:0] F3_RWI = 3'b101;
    localparam logic [2:0] F3_RSI = 3'b110;
    localparam logic [2:0] F3_RCI = 3'b111;

    localparam int unsigned CAUSE_ILLEGAL_INSTR = 2;

    typedef struct packed {
        logic     is_csr;
        logic     writes;
        csr_eff_e eff;
    } op_dec_t;

    function automatic op_dec_t decode_op(input logic [2:0] f3, input logic src_zero);
        op_dec_t d;
        d.is_csr = 1'b1;
        d.writes = 1'b0;
        d.eff    = CSR_RD;
        unique case (f3)
            F3_RW, F3_RWI: begin
                d.writes = 1'b1;
                d.eff    = CSR_WR;
            end
            F3_RS, F3_RSI: begin
                d.writes = ~src_zero;
                d.eff    = src_zero ? CSR_RD : CSR_SET;
            end
            F3_RC, F3_RCI: begin
                d.writes = ~src_zero;
                d.eff    = src_zero ? CSR_RD : CSR_CLR;
            end
            default: d.is_csr = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/csrchk_opdecode.sv
module csrchk_opdecode
    import csrchk_pkg::*;
#(
    parameter int unsigned SRC_W = 5
) (
    input  logic [2:0]       funct3_i,
    input  logic [SRC_W-1:0] src_i,
    output op_dec_t          dec_o
);
    logic src_zero;

    assign src_zero = (src_i == '0);

    always_comb begin
        dec_o = decode_op(funct3_i, src_zero);
    end
endmodule

// File: rtl/csrchk_legality.sv
module csrchk_legality
    import csrchk_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned RO_HI  = 11,
    parameter int unsigned RO_LO  = 10
) (
    input  op_dec_t           dec_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              impl_i,
    output logic              illegal_o
);
    localparam int unsigned RO_W = RO_HI - RO_LO + 1;

    logic read_only;
    logic missing;
    logic ro_write;

    assign read_only = (addr_i[RO_HI:RO_LO] == {RO_W{1'b1}});
    assign missing   = dec_i.is_csr & ~impl_i;
    assign ro_write  = dec_i.is_csr & dec_i.writes & read_only;
    assign illegal_o = missing | ro_write;
endmodule

// File: rtl/csrchk_outreg.sv
module csrchk_outreg
    import csrchk_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned INSTR_W = 32
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               fire_i,
    input  op_dec_t            dec_i,
    input  logic               illegal_i,
    input  logic [INSTR_W-1:0] instr_i,
    output logic [1:0]         eff_op_o,
    output logic               csr_we_o,
    output logic               illegal_o,
    output logic [XLEN-1:0]    cause_o,
    output logic [XLEN-1:0]    tval_o
);
    logic [XLEN-1:0] instr_ext;
    logic            take_exc;
    logic            take_wr;

    generate
        if (INSTR_W < XLEN) begin : g_pad
            assign instr_ext = {{(XLEN-INSTR_W){1'b0}}, instr_i};
        end else begin : g_trunc
            assign instr_ext = instr_i[XLEN-1:0];
        end
    endgenerate

    assign take_exc = fire_i & illegal_i;
    assign take_wr  = fire_i & ~illegal_i & dec_i.is_csr & dec_i.writes;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            eff_op_o  <= CSR_RD;
            csr_we_o  <= 1'b0;
            illegal_o <= 1'b0;
            cause_o   <= '0;
            tval_o    <= '0;
        end else begin
            eff_op_o  <= (fire_i && !illegal_i && dec_i.is_csr) ? dec_i.eff : CSR_RD;
            csr_we_o  <= take_wr;
            illegal_o <= take_exc;
            cause_o   <= take_exc ? XLEN'(CAUSE_ILLEGAL_INSTR) : '0;
            tval_o    <= take_exc ? instr_ext : '0;
        end
    end
endmodule

// File: rtl/csrchk_top.sv
module csrchk_top
    import csrchk_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned INSTR_W = 32,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned SRC_W   = 5
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               instr_valid_i,
    input  logic               stall_i,
    input  logic [2:0]         funct3_i,
    input  logic [SRC_W-1:0]   src_i,
    input  logic [ADDR_W-1:0]  csr_addr_i,
    input  logic               csr_impl_i,
    input  logic [INSTR_W-1:0] instr_i,
    output logic [1:0]         eff_op_o,
    output logic               csr_we_o,
    output logic               illegal_o,
    output logic [XLEN-1:0]    cause_o,
    output logic [XLEN-1:0]    tval_o
);
    localparam int unsigned RO_HI = ADDR_W - 1;
    localparam int unsigned RO_LO = ADDR_W - 2;

    op_dec_t dec;
    logic    illegal;
    logic    fire;

    assign fire = instr_valid_i & ~stall_i;

    csrchk_opdecode #(.SRC_W(SRC_W)) u_dec (
        .funct3_i (funct3_i),
        .src_i    (src_i),
        .dec_o    (dec)
    );

    csrchk_legality #(.ADDR_W(ADDR_W), .RO_HI(RO_HI), .RO_LO(RO_LO)) u_legal (
        .dec_i     (dec),
        .addr_i    (csr_addr_i),
        .impl_i    (csr_impl_i),
        .illegal_o (illegal)
    );

    csrchk_outreg #(.XLEN(XLEN), .INSTR_W(INSTR_W)) u_out (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .fire_i    (fire),
        .dec_i     (dec),
        .illegal_i (illegal),
        .instr_i   (instr_i),
        .eff_op_o  (eff_op_o),
        .csr_we_o  (csr_we_o),
        .illegal_o (illegal_o),
        .cause_o   (cause_o),
        .tval_o    (tval_o)
    );
endmodule

// File: rtl/csrchk_sva.sv
module csrchk_sva
    import csrchk_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned INSTR_W = 32,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned SRC_W   = 5
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               instr_valid_i,
    input logic               stall_i,
    input logic [2:0]         funct3_i,
    input logic [SRC_W-1:0]   src_i,
    input logic [ADDR_W-1:0]  csr_addr_i,
    input logic               csr_impl_i,
    input logic [INSTR_W-1:0] instr_i,
    input logic [1:0]         eff_op_o,
    input logic               csr_we_o,
    input logic               illegal_o,
    input logic [XLEN-1:0]    cause_o,
    input logic [XLEN-1:0]    tval_o
);
    logic acc, reg_setclr, imm_setclr, is_csr, ro_addr, real_wr;

    assign acc        = instr_valid_i & ~stall_i;
    assign reg_setclr = (funct3_i == F3_RS) || (funct3_i == F3_RC);
    assign imm_setclr = (funct3_i == F3_RSI) || (funct3_i == F3_RCI);
    assign is_csr     = (funct3_i[1:0] != 2'b00);
    assign ro_addr    = (csr_addr_i[ADDR_W-1 -: 2] == 2'b11);
    assign real_wr    = (funct3_i == F3_RW) || (funct3_i == F3_RWI)
                        || ((reg_setclr || imm_setclr) && src_i != '0);

    p_reset_r1: assert property (@(posedge clk_i) $past(rst_i) |-> !csr_we_o && !illegal_o);

    p_zero_reg_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) && $past(acc && reg_setclr && src_i == '0) |-> !csr_we_o && eff_op_o == 2'b00);

    p_zero_imm_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) && $past(acc && imm_setclr && src_i == '0) |-> !csr_we_o && eff_op_o == 2'b00);

    p_missing_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) && $past(acc && is_csr && !csr_impl_i) |-> illegal_o);

    p_ro_write_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) && $past(acc && real_wr && ro_addr) |-> illegal_o && !csr_we_o);

    p_excl_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        illegal_o |-> !csr_we_o && eff_op_o == 2'b00);

    p_tval_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) && illegal_o |-> tval_o == XLEN'($past(instr_i)) && cause_o == XLEN'(2));

    p_quiet_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !illegal_o |-> cause_o == '0 && tval_o == '0);

    p_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) && $past(!acc) |-> !csr_we_o && !illegal_o && eff_op_o == 2'b00);
endmodule

bind csrchk_top csrchk_sva #(.XLEN(XLEN), .INSTR_W(INSTR_W), .ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_sva (.*);

// File: tb/sim_csrchk_top.sv
module sim_csrchk_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid, stall, impl;
    logic [2:0]  f3;
    logic [4:0]  src;
    logic [11:0] addr;
    logic [31:0] instr;
    logic [1:0]  eff;
    logic        we, ill;
    logic [31:0] cause, tval;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csrchk_top u0 (
        .clk_i(clk), .rst_i(rst), .instr_valid_i(valid), .stall_i(stall),
        .funct3_i(f3), .src_i(src), .csr_addr_i(addr), .csr_impl_i(impl),
        .instr_i(instr), .eff_op_o(eff), .csr_we_o(we), .illegal_o(ill),
        .cause_o(cause), .tval_o(tval)
    );

    typedef struct packed {
        logic [1:0]  eff;
        logic        we;
        logic        ill;
        logic [31:0] cause;
        logic [31:0] tval;
    } exp_t;

    function automatic exp_t model(logic v, logic s, logic [2:0] fn, logic [4:0] sr,
                                   logic [11:0] a, logic im, logic [31:0] iw);
        exp_t e;
        logic csr, wr, bad;
        logic [1:0] op;
        e = '0;
        csr = (fn != 3'b000) && (fn != 3'b100);
        case (fn[1:0])
            2'b01:   begin op = 2'b01; wr = 1'b1; end
            2'b10:   begin op = (sr == 0) ? 2'b00 : 2'b10; wr = (sr != 0); end
            2'b11:   begin op = (sr == 0) ? 2'b00 : 2'b11; wr = (sr != 0); end
            default: begin op = 2'b00; wr = 1'b0; end
        endcase
        if (!v || s || !csr) return e;
        bad = !im || (wr && a[11:10] == 2'b11);
        if (bad) begin
            e.ill = 1'b1; e.cause = 32'd2; e.tval = iw;
        end else begin
            e.eff = op; e.we = wr;
        end
        return e;
    endfunction

    task automatic check(string req, exp_t e);
        exp_t a;
        a = {eff, we, ill, cause, tval};
        n_run++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s: got eff=%b we=%b ill=%b cause=%0d tval=%h, expected eff=%b we=%b ill=%b cause=%0d tval=%h",
                     req, a.eff, a.we, a.ill, a.cause, a.tval, e.eff, e.we, e.ill, e.cause, e.tval);
        end
    endtask

    // drive at negedge, capture at posedge, check at the next negedge
    task automatic step(string req, logic v, logic s, logic [2:0] fn, logic [4:0] sr,
                        logic [11:0] a, logic im, logic [31:0] iw);
        exp_t e;
        valid = v; stall = s; f3 = fn; src = sr; addr = a; impl = im; instr = iw;
        e = model(v, s, fn, sr, a, im, iw);
        @(negedge clk);
        check(req, e);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c5a1));
        rst = 1; valid = 1; stall = 0; f3 = 3'b001; src = 5'd3;
        addr = 12'h300; impl = 1; instr = 32'hdead_beef;
        @(negedge clk); @(negedge clk);
        check("R1", '0);
        rst = 0;
        valid = 0;
        @(negedge clk);
        check("R1", '0);

        step("R2",  1, 0, 3'b001, 5'd0,  12'h340, 1, 32'h3400_1073);
        step("R2",  1, 0, 3'b101, 5'd0,  12'h340, 1, 32'h3400_5073);
        step("R3",  1, 0, 3'b010, 5'd0,  12'h300, 1, 32'h3000_2073);
        step("R3",  1, 0, 3'b011, 5'd0,  12'h300, 1, 32'h3000_3073);
        step("R4",  1, 0, 3'b110, 5'd0,  12'h300, 1, 32'h3000_6073);
        step("R4",  1, 0, 3'b111, 5'd0,  12'h300, 1, 32'h3000_7073);
        step("R5",  1, 0, 3'b010, 5'd7,  12'h300, 1, 32'h3003_a073);
        step("R5",  1, 0, 3'b111, 5'd31, 12'h300, 1, 32'h300f_f073);
        step("R6",  1, 0, 3'b010, 5'd0,  12'h7c0, 0, 32'h7c00_2073);
        step("R6",  1, 0, 3'b001, 5'd4,  12'h7c0, 0, 32'h7c02_1073);
        step("R7",  1, 0, 3'b001, 5'd1,  12'hc00, 1, 32'hc000_9073);
        step("R7",  1, 0, 3'b110, 5'd0,  12'hf14, 1, 32'hf140_6073);
        step("R7",  1, 0, 3'b011, 5'd2,  12'hf11, 1, 32'hf111_3073);
        step("R8",  1, 0, 3'b101, 5'd9,  12'hc80, 1, 32'hc804_d073);
        step("R9",  1, 0, 3'b001, 5'd1,  12'h305, 0, 32'h3050_9073);
        step("R9",  1, 0, 3'b001, 5'd1,  12'h305, 1, 32'h3050_9073);
        step("R10", 1, 1, 3'b001, 5'd1,  12'h305, 1, 32'h3050_9073);
        step("R10", 1, 1, 3'b001, 5'd1,  12'h305, 0, 32'h3050_9073);
        step("R10", 0, 0, 3'b001, 5'd1,  12'hc00, 1, 32'hc000_9073);
        step("R11", 1, 0, 3'b000, 5'd5,  12'hc00, 0, 32'h0000_0073);
        step("R11", 1, 0, 3'b100, 5'd5,  12'h300, 1, 32'hc000_4073);
        step("R12", 1, 0, 3'b001, 5'd2,  12'h300, 1, 32'h3001_1073);
        step("R12", 1, 0, 3'b001, 5'd2,  12'h300, 1, 32'h3001_1073);

        for (int i = 0; i < 3000; i++) begin
            logic [4:0]  rs;
            logic [11:0] ra;
            rs = ($urandom % 3 == 0) ? 5'd0 : 5'($urandom);
            ra = ($urandom % 3 == 0) ? {2'b11, 10'($urandom)} : 12'($urandom);
            step("R12", ($urandom % 8) != 0, ($urandom % 5) == 0, 3'($urandom),
                 rs, ra, ($urandom % 6) != 0, $urandom);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule